// File: doc/BRIEF.md
# Sequential Floating-Point Significand Multiplier

This block multiplies two operands held in an unpacked floating-point form: a sign bit, a signed exponent, a two-bit class code and a significand built from `N_WORDS` words of `WORD_W` bits each. The lowest `GUARD` bits of every significand are guard positions. A normal number carries its leading one at bit `LEAD = (N_WORDS-1)*WORD_W + TOP_ONE` and no set bit above it. Class codes are ranked by value: 0 zero, 1 number, 2 infinity, 3 NaN.

A one-cycle `start` in the idle state captures both operands. The block then swaps them so that the higher-ranked class sits in the multiplier (y) slot, and settles the special cases in this order: y is NaN, y is infinity, x is zero. When both operands are numbers it forms the product one multiplier bit per cycle. Multiplier bits are taken from the least significant end. Each step shifts the accumulator right into a sticky bit and adds the multiplicand when the bit is set. A zero multiplier word costs one cycle. The product is then normalised by at most one extra shift, and the exponents are summed. The result is valid for the single cycle in which `done` is high. Rounding and packing into a storage format are left to the consumer.

The controller has six named states. IDLE waits for `start`. RESOLVE clears the accumulator and either finishes a special case or begins the multiply. WORD examines the current multiplier word. STEP handles one bit. NORM normalises and forms the exponent. DONE presents the result. The transitions are:
- IDLE→RESOLVE on start.
- RESOLVE→DONE for a special case; RESOLVE→WORD for two numbers.
- WORD→WORD when a non-top word is zero (skip).
- WORD→STEP otherwise.
- STEP→STEP within a word.
- STEP→WORD at the end of a non-top word.
- STEP→NORM once the top word has no set bit left above the current position.
- NORM→DONE.
- DONE→IDLE.

Top module: `fmul_seq`

## Requirements
- R1: After reset, `busy` and `done` are both low.
- R2: A `start` seen while idle raises `busy` on the next cycle. `done` is high for exactly one cycle, during which `busy` is also high. `busy` is low on the cycle after `done`.
- R3: Operands are swapped only when the class code of a is greater than that of b. If the resulting y is NaN, the result is y's exponent, significand and class with sign x XOR y, and flag bit 0 (invalid: NaN operand) is set.
- R4: Infinity times zero, in either order, gives class NaN, sign 0, exponent 0, and a significand with only bits `LEAD` and `LEAD-1` set. Flag bit 1 (invalid: infinity times zero) is set.
- R5: Infinity times a number or infinity gives class infinity with y's exponent and significand and sign XOR. Zero times zero or a number gives class zero with x's exponent and significand and sign XOR. Both leave the flags and sticky bit at zero.
- R6: For two numbers, the result significand is floor(X·Y / 2^LEAD). If that value reaches 2^(LEAD+1), the significand is shifted right once more. The sticky bit is the OR of every discarded product bit, and the class is number with sign XOR and flags zero.
- R7: The exponent of a numeric result is the sum of the input exponents modulo 2^EXP_W, plus one when the extra normalising shift happened.
- R8: A special case raises `done` two clock edges after the edge that captured `start`. A numeric multiply raises `done` 3 + Σ edges after it, where each word contributes one cycle plus its bit steps. The bit steps are `WORD_W-GUARD` for a nonzero lowest word, `WORD_W` for a nonzero middle word, zero for any zero non-top word, and (highest set bit + 1) for the top word.
- R9: A zero multiplier word below the top word, including the lowest word, costs exactly one cycle.
- R10: A `start` pulse while `busy` is high is ignored, and operand inputs may change after the capturing edge without affecting the result or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiply; sampled only when idle |
| a_sign | input | 1 | Sign of operand a |
| a_exp | input | EXP_W | Exponent of operand a, two's complement |
| a_cls | input | 2 | Class of operand a (0 zero, 1 number, 2 infinity, 3 NaN) |
| a_mant | input | WORD_W*N_WORDS | Significand of operand a |
| b_sign | input | 1 | Sign of operand b |
| b_exp | input | EXP_W | Exponent of operand b |
| b_cls | input | 2 | Class of operand b |
| b_mant | input | WORD_W*N_WORDS | Significand of operand b; guard bits zero |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle result-valid strobe |
| r_sign | output | 1 | Result sign |
| r_exp | output | EXP_W | Result exponent |
| r_cls | output | 2 | Result class |
| r_mant | output | WORD_W*N_WORDS | Result significand |
| r_sticky | output | 1 | OR of product bits discarded below the result |
| r_flags | output | 2 | Bit 0 NaN-operand invalid, bit 1 infinity-times-zero invalid |

## Verification
Two functions can act in the same cycle: the extra normalising shift in NORM and the exponent sum. Both use the pre-shift accumulator top, so a wrong ordering shows up as an exponent that is off by one. Maximal significands force that shift, and the bench compares exponent, significand and sticky against a full-width reference product in the done cycle. A stray `start` is also issued with scrambled operand inputs in the middle of a multiply. `done` is then judged on every clock against the latency predicted from the multiplier words, so an ignored start must neither move the done edge nor alter the result.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NUM  = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } cls_e;

    typedef enum logic [2:0] {
        CASE_NUM,
        CASE_YNAN,
        CASE_INF,
        CASE_INFZERO,
        CASE_ZERO
    } case_e;

    typedef enum logic [2:0] {
        ACC_HOLD,
        ACC_CLEAR,
        ACC_STEP,
        ACC_SKIP,
        ACC_NORM
    } acc_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESOLVE,
        ST_WORD,
        ST_STEP,
        ST_NORM,
        ST_DONE
    } state_e;

endpackage

// File: rtl/fmul_order.sv
module fmul_order
    import fmul_pkg::*;
#(
    parameter int MANT_W = 128,
    parameter int EXP_W  = 16
) (
    input  logic              a_sign,
    input  logic [EXP_W-1:0]  a_exp,
    input  logic [1:0]        a_cls,
    input  logic [MANT_W-1:0] a_mant,
    input  logic              b_sign,
    input  logic [EXP_W-1:0]  b_exp,
    input  logic [1:0]        b_cls,
    input  logic [MANT_W-1:0] b_mant,
    output logic              x_sign,
    output logic [EXP_W-1:0]  x_exp,
    output logic [MANT_W-1:0] x_mant,
    output logic              y_sign,
    output logic [EXP_W-1:0]  y_exp,
    output logic [1:0]        y_cls,
    output logic [MANT_W-1:0] y_mant,
    output case_e             case_code
);

    logic swap;
    cls_e x_c;
    cls_e y_c;

    // higher class code ranks higher; it goes to the y slot
    assign swap = (a_cls > b_cls);

    always_comb begin
        if (swap) begin
            x_sign = b_sign;  x_exp = b_exp;  x_c = cls_e'(b_cls);  x_mant = b_mant;
            y_sign = a_sign;  y_exp = a_exp;  y_c = cls_e'(a_cls);  y_mant = a_mant;
        end else begin
            x_sign = a_sign;  x_exp = a_exp;  x_c = cls_e'(a_cls);  x_mant = a_mant;
            y_sign = b_sign;  y_exp = b_exp;  y_c = cls_e'(b_cls);  y_mant = b_mant;
        end
    end

    assign y_cls = y_c;

    always_comb begin
        if (y_c == CLS_NAN) begin
            case_code = CASE_YNAN;
        end else if (y_c == CLS_INF) begin
            case_code = (x_c == CLS_ZERO) ? CASE_INFZERO : CASE_INF;
        end else if (x_c == CLS_ZERO) begin
            case_code = CASE_ZERO;
        end else begin
            case_code = CASE_NUM;
        end
    end

endmodule

// File: rtl/fmul_accum.sv
module fmul_accum
    import fmul_pkg::*;
#(
    parameter int MANT_W = 128,
    parameter int WORD_W = 32,
    parameter int LEAD   = 114
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_op_e           op,
    input  logic              add_en,
    input  logic [MANT_W-1:0] mcand,
    output logic [MANT_W-1:0] acc,
    output logic              sticky,
    output logic              over2
);

    // product at or above 2.0 needs one more right shift
    assign over2 = |acc[MANT_W-1:LEAD+1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            sticky <= 1'b0;
        end else begin
            unique case (op)
                ACC_CLEAR: begin
                    acc    <= '0;
                    sticky <= 1'b0;
                end
                ACC_STEP: begin
                    acc    <= (acc >> 1) + (add_en ? mcand : '0);
                    sticky <= sticky | acc[0];
                end
                ACC_SKIP: begin
                    acc    <= acc >> WORD_W;
                    sticky <= sticky | (|acc[WORD_W-1:0]);
                end
                ACC_NORM: begin
                    if (over2) begin
                        acc    <= acc >> 1;
                        sticky <= sticky | acc[0];
                    end
                end
                default: begin
                    acc    <= acc;
                    sticky <= sticky;
                end
            endcase
        end
    end

endmodule

// File: rtl/fmul_ctrl.sv
module fmul_ctrl
    import fmul_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 4,
    parameter int GUARD   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  case_e                     case_code,
    input  logic [WORD_W*N_WORDS-1:0] y_mant,
    output acc_op_e                   acc_op,
    output logic                      add_en,
    output logic                      capture,
    output logic                      load_special,
    output logic                      load_num,
    output logic                      busy,
    output logic                      done
);

    localparam int WIDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
    localparam int BIDX_W = $clog2(WORD_W);
    localparam logic [WIDX_W-1:0] TOP_IDX = WIDX_W'(N_WORDS - 1);
    localparam logic [BIDX_W-1:0] LAST_BIT = BIDX_W'(WORD_W - 1);
    localparam logic [BIDX_W-1:0] FIRST_LOW = BIDX_W'(GUARD);

    state_e state;
    state_e nxt;
    logic [WIDX_W-1:0] widx;
    logic [BIDX_W-1:0] bidx;

    logic [WORD_W-1:0] cur_word;
    logic word_zero;
    logic is_top;
    logic is_low;
    logic bit_set;
    logic none_above;
    logic last_in_word;

    assign cur_word     = y_mant[widx*WORD_W +: WORD_W];
    assign word_zero    = (cur_word == '0);
    assign is_top       = (widx == TOP_IDX);
    assign is_low       = (widx == '0);
    assign bit_set      = cur_word[bidx];
    assign none_above   = (((cur_word >> bidx) >> 1) == '0);
    assign last_in_word = (bidx == LAST_BIT);

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_RESOLVE;
            ST_RESOLVE: nxt = (case_code == CASE_NUM) ? ST_WORD : ST_DONE;
            ST_WORD:    nxt = (!is_top && word_zero) ? ST_WORD : ST_STEP;
            ST_STEP: begin
                if (is_top) begin
                    if (none_above) nxt = ST_NORM;
                end else if (last_in_word) begin
                    nxt = ST_WORD;
                end
            end
            ST_NORM:    nxt = ST_DONE;
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // state register with word and bit position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            widx  <= '0;
            bidx  <= '0;
        end else begin
            state <= nxt;
            unique case (state)
                ST_RESOLVE: begin
                    widx <= '0;
                    bidx <= '0;
                end
                ST_WORD: begin
                    if (!is_top && word_zero) begin
                        widx <= widx + 1'b1;
                    end else begin
                        bidx <= is_low ? FIRST_LOW : '0;
                    end
                end
                ST_STEP: begin
                    if (!is_top && last_in_word) begin
                        widx <= widx + 1'b1;
                    end else begin
                        bidx <= bidx + 1'b1;
                    end
                end
                default: begin
                    widx <= widx;
                    bidx <= bidx;
                end
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        acc_op       = ACC_HOLD;
        add_en       = 1'b0;
        capture      = 1'b0;
        load_special = 1'b0;
        load_num     = 1'b0;
        busy         = (state != ST_IDLE);
        done         = (state == ST_DONE);
        unique case (state)
            ST_IDLE:    capture = start;
            ST_RESOLVE: begin
                acc_op       = ACC_CLEAR;
                load_special = (case_code != CASE_NUM);
            end
            ST_WORD: begin
                // lowest word: accumulator still zero, skip needs no shift
                if (!is_top && word_zero && !is_low) acc_op = ACC_SKIP;
            end
            ST_STEP: begin
                acc_op = ACC_STEP;
                add_en = bit_set;
            end
            ST_NORM: begin
                acc_op   = ACC_NORM;
                load_num = 1'b1;
            end
            default: begin
                acc_op = ACC_HOLD;
            end
        endcase
    end

endmodule

// File: rtl/fmul_seq.sv
module fmul_seq
    import fmul_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 4,
    parameter int GUARD   = 2,
    parameter int TOP_ONE = 18,
    parameter int EXP_W   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      a_sign,
    input  logic [EXP_W-1:0]          a_exp,
    input  logic [1:0]                a_cls,
    input  logic [WORD_W*N_WORDS-1:0] a_mant,
    input  logic                      b_sign,
    input  logic [EXP_W-1:0]          b_exp,
    input  logic [1:0]                b_cls,
    input  logic [WORD_W*N_WORDS-1:0] b_mant,
    output logic                      busy,
    output logic                      done,
    output logic                      r_sign,
    output logic [EXP_W-1:0]          r_exp,
    output logic [1:0]                r_cls,
    output logic [WORD_W*N_WORDS-1:0] r_mant,
    output logic                      r_sticky,
    output logic [1:0]                r_flags
);

    localparam int MANT_W = WORD_W * N_WORDS;
    localparam int LEAD   = (N_WORDS - 1) * WORD_W + TOP_ONE;
    localparam logic [MANT_W-1:0] QNAN_MANT =
        (MANT_W'(1) << LEAD) | (MANT_W'(1) << (LEAD - 1));

    // captured operands
    logic              la_sign, lb_sign;
    logic [EXP_W-1:0]  la_exp, lb_exp;
    logic [1:0]        la_cls, lb_cls;
    logic [MANT_W-1:0] la_mant, lb_mant;

    logic              x_sign, y_sign;
    logic [EXP_W-1:0]  x_exp, y_exp;
    logic [1:0]        y_cls;
    logic [MANT_W-1:0] x_mant, y_mant;
    case_e             case_code;

    acc_op_e           acc_op;
    logic              add_en, capture, load_special, load_num;
    logic [MANT_W-1:0] acc;
    logic              acc_sticky, over2;

    logic              sp_sign;
    logic [EXP_W-1:0]  sp_exp;
    logic [1:0]        sp_cls;
    logic [MANT_W-1:0] sp_mant;
    logic [1:0]        sp_flags;

    logic              res_sign;
    logic [EXP_W-1:0]  res_exp;
    logic [1:0]        res_cls;
    logic [MANT_W-1:0] res_mant;
    logic [1:0]        res_flags;
    logic              from_acc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            la_sign <= 1'b0;  la_exp <= '0;  la_cls <= '0;  la_mant <= '0;
            lb_sign <= 1'b0;  lb_exp <= '0;  lb_cls <= '0;  lb_mant <= '0;
        end else if (capture) begin
            la_sign <= a_sign;  la_exp <= a_exp;  la_cls <= a_cls;  la_mant <= a_mant;
            lb_sign <= b_sign;  lb_exp <= b_exp;  lb_cls <= b_cls;  lb_mant <= b_mant;
        end
    end

    fmul_order #(.MANT_W(MANT_W), .EXP_W(EXP_W)) i_order (
        .a_sign(la_sign), .a_exp(la_exp), .a_cls(la_cls), .a_mant(la_mant),
        .b_sign(lb_sign), .b_exp(lb_exp), .b_cls(lb_cls), .b_mant(lb_mant),
        .x_sign(x_sign), .x_exp(x_exp), .x_mant(x_mant),
        .y_sign(y_sign), .y_exp(y_exp), .y_cls(y_cls), .y_mant(y_mant),
        .case_code(case_code)
    );

    fmul_ctrl #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .GUARD(GUARD)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .case_code(case_code), .y_mant(y_mant),
        .acc_op(acc_op), .add_en(add_en), .capture(capture),
        .load_special(load_special), .load_num(load_num),
        .busy(busy), .done(done)
    );

    fmul_accum #(.MANT_W(MANT_W), .WORD_W(WORD_W), .LEAD(LEAD)) i_accum (
        .clk(clk), .rst_n(rst_n), .op(acc_op), .add_en(add_en),
        .mcand(x_mant), .acc(acc), .sticky(acc_sticky), .over2(over2)
    );

    // special-case result selection
    always_comb begin
        sp_sign  = x_sign ^ y_sign;
        sp_exp   = y_exp;
        sp_cls   = y_cls;
        sp_mant  = y_mant;
        sp_flags = 2'b00;
        unique case (case_code)
            CASE_YNAN: begin
                sp_cls   = CLS_NAN;
                sp_flags = 2'b01;
            end
            CASE_INFZERO: begin
                sp_sign  = 1'b0;
                sp_exp   = '0;
                sp_cls   = CLS_NAN;
                sp_mant  = QNAN_MANT;
                sp_flags = 2'b10;
            end
            CASE_INF: sp_cls = CLS_INF;
            CASE_ZERO: begin
                sp_exp  = x_exp;
                sp_cls  = CLS_ZERO;
                sp_mant = x_mant;
            end
            default: sp_cls = CLS_NUM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_sign  <= 1'b0;
            res_exp   <= '0;
            res_cls   <= '0;
            res_mant  <= '0;
            res_flags <= '0;
            from_acc  <= 1'b0;
        end else if (load_special) begin
            res_sign  <= sp_sign;
            res_exp   <= sp_exp;
            res_cls   <= sp_cls;
            res_mant  <= sp_mant;
            res_flags <= sp_flags;
            from_acc  <= 1'b0;
        end else if (load_num) begin
            res_sign  <= x_sign ^ y_sign;
            res_exp   <= x_exp + y_exp + {{(EXP_W-1){1'b0}}, over2};
            res_cls   <= CLS_NUM;
            res_flags <= 2'b00;
            from_acc  <= 1'b1;
        end
    end

    assign r_sign   = res_sign;
    assign r_exp    = res_exp;
    assign r_cls    = res_cls;
    assign r_flags  = res_flags;
    assign r_mant   = from_acc ? acc : res_mant;
    assign r_sticky = from_acc & acc_sticky;

endmodule

// File: rtl/fmul_seq_chk.sv
module fmul_seq_chk #(
    parameter int MANT_W = 128,
    parameter int LEAD   = 114
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [1:0]        r_cls,
    input logic [1:0]        r_flags,
    input logic [MANT_W-1:0] r_mant,
    input logic              r_sticky
);

    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_idle_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot0(r_flags));

    p_nan_flag_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_flags[0]) |-> (r_cls == 2'd3));

    p_infzero_nan_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_flags[1]) |-> (r_cls == 2'd3 && r_mant[LEAD] && r_mant[LEAD-1]));

    p_special_no_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_cls != 2'd1) |-> !r_sticky);

    p_normalised_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_cls == 2'd1) |-> (r_mant[LEAD] && r_mant[MANT_W-1:LEAD+1] == '0));

endmodule

bind fmul_seq fmul_seq_chk #(.MANT_W(MANT_W), .LEAD(LEAD)) i_fmul_seq_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .r_cls(r_cls), .r_flags(r_flags), .r_mant(r_mant), .r_sticky(r_sticky)
);

// File: tb/test_fmul_seq.sv
module test_fmul_seq;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W  = 32;
    localparam int N_WORDS = 4;
    localparam int GUARD   = 2;
    localparam int TOP_ONE = 18;
    localparam int EXP_W   = 16;
    localparam int MANT_W  = WORD_W * N_WORDS;
    localparam int LEAD    = (N_WORDS - 1) * WORD_W + TOP_ONE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic a_sign = 1'b0, b_sign = 1'b0;
    logic [EXP_W-1:0] a_exp = '0, b_exp = '0;
    logic [1:0] a_cls = '0, b_cls = '0;
    logic [MANT_W-1:0] a_mant = '0, b_mant = '0;
    logic busy, done, r_sign, r_sticky;
    logic [EXP_W-1:0] r_exp;
    logic [1:0] r_cls, r_flags;
    logic [MANT_W-1:0] r_mant;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fmul_seq #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .GUARD(GUARD),
               .TOP_ONE(TOP_ONE), .EXP_W(EXP_W)) i_fmul_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_sign(a_sign), .a_exp(a_exp), .a_cls(a_cls), .a_mant(a_mant),
        .b_sign(b_sign), .b_exp(b_exp), .b_cls(b_cls), .b_mant(b_mant),
        .busy(busy), .done(done), .r_sign(r_sign), .r_exp(r_exp),
        .r_cls(r_cls), .r_mant(r_mant), .r_sticky(r_sticky), .r_flags(r_flags)
    );

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [MANT_W-1:0] rnd_mant();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    // force a normal significand: leading one at LEAD, guard bits cleared
    function automatic logic [MANT_W-1:0] mk_num(input logic [MANT_W-1:0] r);
        logic [MANT_W-1:0] m;
        m = r & ((MANT_W'(1) << (LEAD + 1)) - 1);
        m = m | (MANT_W'(1) << LEAD);
        m = m & ~((MANT_W'(1) << GUARD) - 1);
        return m;
    endfunction

    // R8/R9 latency model from the multiplier word contents
    function automatic int num_latency(input logic [MANT_W-1:0] y);
        int l;
        int hs;
        logic [WORD_W-1:0] w;
        l = 3;
        for (int i = 0; i < N_WORDS - 1; i++) begin
            w = y[i*WORD_W +: WORD_W];
            l += 1;
            if (w != '0) l += (i == 0) ? (WORD_W - GUARD) : WORD_W;
        end
        w = y[(N_WORDS-1)*WORD_W +: WORD_W];
        hs = 0;
        for (int j = 0; j < WORD_W; j++) if (w[j]) hs = j;
        l += 1 + hs + 1;
        return l;
    endfunction

    task automatic do_op(input logic as, input logic [EXP_W-1:0] ae, input logic [1:0] ac,
                         input logic [MANT_W-1:0] am,
                         input logic bs, input logic [EXP_W-1:0] be, input logic [1:0] bc,
                         input logic [MANT_W-1:0] bm,
                         input bit poke, input string tag);
        logic xs, ys;
        logic [EXP_W-1:0] xe, ye;
        logic [1:0] xc, yc;
        logic [MANT_W-1:0] xm, ym;
        logic e_sign, e_sticky;
        logic [EXP_W-1:0] e_exp;
        logic [1:0] e_cls, e_flags;
        logic [MANT_W-1:0] e_mant;
        logic [255:0] p, q;
        int lat, k;
        bit tok;
        string treq;
        string sreq;
        // R3 ordering: swap when a ranks above b
        if (ac > bc) begin
            xs = bs; xe = be; xc = bc; xm = bm; ys = as; ye = ae; yc = ac; ym = am;
        end else begin
            xs = as; xe = ae; xc = ac; xm = am; ys = bs; ye = be; yc = bc; ym = bm;
        end
        e_sticky = 1'b0;
        e_flags  = 2'b00;
        e_sign   = xs ^ ys;
        lat = 2;
        if (yc == 2'd3) begin
            e_exp = ye; e_cls = 2'd3; e_mant = ym; e_flags = 2'b01; sreq = "R3";
        end else if (yc == 2'd2 && xc == 2'd0) begin
            e_sign = 1'b0; e_exp = '0; e_cls = 2'd3;
            e_mant = (MANT_W'(1) << LEAD) | (MANT_W'(1) << (LEAD - 1));
            e_flags = 2'b10; sreq = "R4";
        end else if (yc == 2'd2) begin
            e_exp = ye; e_cls = 2'd2; e_mant = ym; sreq = "R5";
        end else if (xc == 2'd0) begin
            e_exp = xe; e_cls = 2'd0; e_mant = xm; sreq = "R5";
        end else begin
            sreq = "R6";
            e_cls = 2'd1;
            p = {{(256-MANT_W){1'b0}}, xm} * {{(256-MANT_W){1'b0}}, ym};
            q = p >> LEAD;
            if (q >= (256'd1 << (LEAD + 1))) begin
                e_mant = MANT_W'(p >> (LEAD + 1));
                e_sticky = |(p & ((256'd1 << (LEAD + 1)) - 1));
                e_exp = xe + ye + 1'b1;
            end else begin
                e_mant = MANT_W'(q);
                e_sticky = |(p & ((256'd1 << LEAD) - 1));
                e_exp = xe + ye;
            end
            lat = num_latency(ym);
        end
        treq = (sreq == "R6") ? "R8 R9" : "R8";

        @(negedge clk);
        a_sign = as; a_exp = ae; a_cls = ac; a_mant = am;
        b_sign = bs; b_exp = be; b_cls = bc; b_mant = bm;
        start = 1'b1;
        tok = 1'b1;
        k = 0;
        while (k < lat) begin
            @(negedge clk);
            k++;
            start = 1'b0;
            if (busy !== 1'b1 || done !== (k == lat)) begin
                if (tok) $display("FAIL %s %s timing at edge %0d: busy=%0b done=%0b expected done at %0d",
                                  treq, tag, k, busy, done, lat);
                tok = 1'b0;
            end
            if (poke && k == 4) begin
                // R10: stray start and scrambled operands while busy
                start = 1'b1;
                a_mant = ~a_mant; b_mant = rnd_mant(); a_exp = ~a_exp; a_cls = 2'd3;
            end
        end
        tests++;
        if (!tok) fails++;
        chk(r_mant === e_mant, {sreq, " mant ", tag}, 256'(r_mant), 256'(e_mant));
        chk(r_sticky === e_sticky, {sreq, " sticky ", tag}, 256'(r_sticky), 256'(e_sticky));
        chk(r_cls === e_cls && r_flags === e_flags && r_sign === e_sign,
            {sreq, " cls/flags/sign ", tag},
            256'({r_cls, r_flags, r_sign}), 256'({e_cls, e_flags, e_sign}));
        chk(r_exp === e_exp, {(sreq == "R6") ? "R7" : sreq, " exp ", tag},
            256'(r_exp), 256'(e_exp));
        if (poke) chk(tok, {"R10 ignored start ", tag}, 256'(k), 256'(lat));
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b0 && done === 1'b0, {"R2 idle after done ", tag},
            256'({busy, done}), 256'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [MANT_W-1:0] one, big, ym;
        one = MANT_W'(1) << LEAD;
        big = mk_num('1);
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1 reset state", 256'({busy, done}), 256'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1 idle after reset", 256'({busy, done}), 256'(0));

        // numeric products: random patterns
        for (int i = 0; i < 12; i++) begin
            do_op(1'($urandom()), 16'($urandom()), 2'd1, mk_num({rnd_mant()[MANT_W-1:2], 2'($urandom())}),
                  1'($urandom()), 16'($urandom()), 2'd1, mk_num(rnd_mant()), 1'b0, "R6 random");
        end
        do_op(1'b0, 16'd5, 2'd1, one, 1'b1, 16'hfffd, 2'd1, mk_num(rnd_mant()), 1'b0, "R6 x=1");
        do_op(1'b1, 16'h7fff, 2'd1, big, 1'b1, 16'd1, 2'd1, big, 1'b0, "R7 max wrap");
        do_op(1'b0, 16'd3, 2'd1, one, 1'b0, 16'd4, 2'd1, one, 1'b0, "R9 y=1 all low zero");
        ym = mk_num(rnd_mant());
        ym[WORD_W-1:0] = '0;
        do_op(1'b0, 16'd9, 2'd1, big, 1'b0, 16'd2, 2'd1, ym, 1'b0, "R9 low word zero");
        ym = mk_num(rnd_mant());
        ym[2*WORD_W +: WORD_W] = '0;
        ym[WORD_W +: WORD_W] = '0;
        do_op(1'b1, 16'd1, 2'd1, mk_num(rnd_mant()), 1'b0, 16'd1, 2'd1, ym, 1'b0, "R9 middle zero");
        do_op(1'b0, 16'd7, 2'd1, mk_num(rnd_mant()), 1'b1, 16'd8, 2'd1, mk_num(rnd_mant()), 1'b1, "R10 poke");

        // special operands
        do_op(1'b1, 16'd11, 2'd3, rnd_mant(), 1'b0, 16'd2, 2'd1, one, 1'b0, "R3 nan x num");
        do_op(1'b1, 16'd2, 2'd1, one, 1'b1, 16'd13, 2'd3, rnd_mant(), 1'b0, "R3 num x nan");
        do_op(1'b0, 16'd21, 2'd3, rnd_mant(), 1'b1, 16'd22, 2'd3, rnd_mant(), 1'b0, "R3 nan x nan");
        do_op(1'b0, 16'd1, 2'd2, one, 1'b0, 16'd6, 2'd3, rnd_mant(), 1'b0, "R3 inf x nan");
        do_op(1'b1, 16'd30, 2'd2, one, 1'b1, 16'd0, 2'd0, '0, 1'b0, "R4 inf x zero");
        do_op(1'b0, 16'd0, 2'd0, '0, 1'b1, 16'd31, 2'd2, one, 1'b0, "R4 zero x inf");
        do_op(1'b1, 16'd40, 2'd2, big, 1'b0, 16'd4, 2'd1, one, 1'b0, "R5 inf x num");
        do_op(1'b1, 16'd41, 2'd2, one, 1'b1, 16'd42, 2'd2, big, 1'b0, "R5 inf x inf");
        do_op(1'b0, 16'd3, 2'd1, big, 1'b1, 16'd0, 2'd0, '0, 1'b0, "R5 num x zero");
        do_op(1'b1, 16'd0, 2'd0, '0, 1'b1, 16'd0, 2'd0, '0, 1'b0, "R5 zero x zero");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule